// File: doc/BRIEF.md
# Subtile-Clipped Region Walk Sequencer

This block takes a rectangular pixel region (origin x, y and extent width, height) and walks it as a series of pieces. Each piece is the part of the region that falls inside one subtile of the tiled surface. A subtile is 4 microtiles wide and 4 microtiles tall, and one subtile holds 1024 bytes. Pieces come out one row of subtiles at a time, left to right within a row, starting at the top row. Each piece carries five things: its origin inside its subtile, its clipped width and height, a byte offset into the linear (untiled) buffer, and the microtile coordinates of the subtile origin. A tiled address generator downstream uses those coordinates. A transfer-direction bit captured at start is passed through unchanged.

The block is used through a start/busy/done handshake. A start pulse while idle captures the region, the direction and the linear stride in bytes. Pieces are then offered on a valid/ready output. The region must be aligned to microtile boundaries. A misaligned request is rejected with an error pulse and produces nothing.

Top module: `region_walk_seq`

## Requirements
- R1: After a synchronous reset, busy, done, align_err and piece_valid are all low.
- R2: Pieces are offered in row-major order. The first row of subtiles is walked left to right, then the next row down. Columns step from x to the next multiple of the subtile width, or to x+width if that comes first. Rows step the same way on the y axis.
- R3: For each piece, piece_sx = x mod subtile width and piece_w = min(x_end - x, subtile width - piece_sx). The y axis follows the same rule for piece_sy and piece_h.
- R4: piece_utx is floor(x / microtile width) with its two low bits cleared. piece_uty is floor(y / microtile height) with its two low bits cleared.
- R5: piece_lin_off is the sum of a row base and a column offset. The column offset starts at 0 on every row of pieces and grows by piece_w * BPP after each accepted piece. The row base starts at 0 and grows by stride * piece_h when a row ends.
- R6: While piece_valid is high and piece_ready is low, piece_valid stays high and every piece field holds its value.
- R7: done is high for exactly one cycle, the cycle right after the last piece is accepted. busy is low in that cycle.
- R8: A correctly aligned region with zero width or zero height raises done in the cycle after start and offers no pieces.
- R9: If x, width, y or height is not a multiple of the microtile size on its axis, align_err is high for one cycle after start. No pieces are offered, done stays low and busy stays low.
- R10: piece_dir equals the dir input sampled at start, on every piece of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a walk (sampled while idle) |
| dir | input | 1 | Transfer direction, carried to pieces |
| reg_x | input | CW | Region origin x in pixels |
| reg_y | input | CW | Region origin y in pixels |
| reg_w | input | CW | Region width in pixels |
| reg_h | input | CW | Region height in pixels |
| lin_stride | input | OW | Linear buffer row pitch in bytes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle misalignment pulse |
| piece_valid | output | 1 | Piece offered |
| piece_ready | input | 1 | Piece accepted when high with valid |
| piece_dir | output | 1 | Carried direction bit |
| piece_sx | output | CW | Piece x within subtile |
| piece_sy | output | CW | Piece y within subtile |
| piece_w | output | CW | Piece width in pixels |
| piece_h | output | CW | Piece height in pixels |
| piece_lin_off | output | OW | Byte offset in linear buffer |
| piece_utx | output | CW | Subtile origin, microtile x |
| piece_uty | output | CW | Subtile origin, microtile y |

## Verification
The bench is built with microtiles that are wider than they are tall, so a swap of the x and y arithmetic cannot go unnoticed. It sweeps every microtile-aligned origin over two subtiles on each axis. It crosses those origins with extents that fit inside one subtile, extents that straddle a boundary, and extents that span several subtiles. This separates origins that start flush on a boundary from origins that start mid-subtile, and it exercises the last clipped piece of each row. Alternate regions stall the ready input, which checks that each piece holds. Zero-extent and misaligned requests are run separately, to tell immediate completion apart from rejection.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } walk_state_t;
endpackage

// File: rtl/rws_axis_step.sv
module rws_axis_step #(
  parameter int UT = 4,
  parameter int CW = 12
) (
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] stop,
  output logic [CW-1:0] in_sub,
  output logic [CW-1:0] size,
  output logic [CW-1:0] nxt,
  output logic [CW-1:0] utile,
  output logic          last
);
  localparam int SUB   = 4 * UT;
  localparam int UT_LG = $clog2(UT);

  logic [CW-1:0] left;
  logic [CW-1:0] room;
  logic [CW-1:0] ushift;

  always_comb begin
    in_sub = pos & CW'(SUB - 1);
    left   = stop - pos;
    room   = CW'(SUB) - in_sub;
    size   = (left < room) ? left : room;
    nxt    = pos + size;
    last   = (nxt >= stop);
    ushift = pos >> UT_LG;
    utile  = ushift & ~CW'(3);
  end
endmodule

// File: rtl/rws_lin_track.sv
module rws_lin_track #(
  parameter int OW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step_col,
  input  logic          step_row,
  input  logic [OW-1:0] col_bytes,
  input  logic [OW-1:0] row_bytes,
  output logic [OW-1:0] offset
);
  logic [OW-1:0] row_base;
  logic [OW-1:0] col_off;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      row_base <= '0;
      col_off  <= '0;
    end else if (step_row) begin
      row_base <= row_base + row_bytes;
      col_off  <= '0;
    end else if (step_col) begin
      col_off <= col_off + col_bytes;
    end
  end

  assign offset = row_base + col_off;
endmodule

// File: rtl/region_walk_seq.sv
module region_walk_seq #(
  parameter int UTW = 4,
  parameter int UTH = 4,
  parameter int BPP = 4,
  parameter int CW  = 12,
  parameter int OW  = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir,
  input  logic [CW-1:0] reg_x,
  input  logic [CW-1:0] reg_y,
  input  logic [CW-1:0] reg_w,
  input  logic [CW-1:0] reg_h,
  input  logic [OW-1:0] lin_stride,
  output logic          busy,
  output logic          done,
  output logic          align_err,
  output logic          piece_valid,
  input  logic          piece_ready,
  output logic          piece_dir,
  output logic [CW-1:0] piece_sx,
  output logic [CW-1:0] piece_sy,
  output logic [CW-1:0] piece_w,
  output logic [CW-1:0] piece_h,
  output logic [OW-1:0] piece_lin_off,
  output logic [CW-1:0] piece_utx,
  output logic [CW-1:0] piece_uty
);
  import rws_pkg::*;

  walk_state_t   st;
  logic [CW-1:0] x0, x_end, y_end, cur_x, cur_y;
  logic [OW-1:0] stride_q;
  logic          dir_q;

  logic [CW-1:0] x_nxt, y_nxt;
  logic          x_last, y_last;
  logic          misaligned, empty, take, fire;

  rws_axis_step #(.UT(UTW), .CW(CW)) i_xstep (
    .pos(cur_x), .stop(x_end), .in_sub(piece_sx), .size(piece_w),
    .nxt(x_nxt), .utile(piece_utx), .last(x_last)
  );

  rws_axis_step #(.UT(UTH), .CW(CW)) i_ystep (
    .pos(cur_y), .stop(y_end), .in_sub(piece_sy), .size(piece_h),
    .nxt(y_nxt), .utile(piece_uty), .last(y_last)
  );

  always_comb begin
    misaligned = ((reg_x & CW'(UTW - 1)) != '0) || ((reg_w & CW'(UTW - 1)) != '0)
              || ((reg_y & CW'(UTH - 1)) != '0) || ((reg_h & CW'(UTH - 1)) != '0);
    empty      = (reg_w == '0) || (reg_h == '0);
    take       = (st == ST_IDLE) && start;
    fire       = (st == ST_EMIT) && piece_ready;
  end

  rws_lin_track #(.OW(OW)) i_lin (
    .clk(clk), .rst(rst), .clear(take),
    .step_col(fire && !x_last),
    .step_row(fire && x_last && !y_last),
    .col_bytes(OW'(piece_w) * OW'(BPP)),
    .row_bytes(stride_q * OW'(piece_h)),
    .offset(piece_lin_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      align_err <= 1'b0;
      x0        <= '0;
      x_end     <= '0;
      y_end     <= '0;
      cur_x     <= '0;
      cur_y     <= '0;
      stride_q  <= '0;
      dir_q     <= 1'b0;
    end else begin
      done      <= 1'b0;
      align_err <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          x0       <= reg_x;
          cur_x    <= reg_x;
          cur_y    <= reg_y;
          x_end    <= reg_x + reg_w;
          y_end    <= reg_y + reg_h;
          stride_q <= lin_stride;
          dir_q    <= dir;
          if (misaligned)  align_err <= 1'b1;
          else if (empty)  done      <= 1'b1;
          else             st        <= ST_EMIT;
        end
        ST_EMIT: if (piece_ready) begin
          if (!x_last) begin
            cur_x <= x_nxt;
          end else if (!y_last) begin
            cur_x <= x0;
            cur_y <= y_nxt;
          end else begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st != ST_IDLE);
  assign piece_valid = (st == ST_EMIT);
  assign piece_dir   = dir_q;
endmodule

// File: rtl/region_walk_seq_chk.sv
module region_walk_seq_chk #(
  parameter int UTW = 4,
  parameter int UTH = 4,
  parameter int CW  = 12,
  parameter int OW  = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          align_err,
  input logic          piece_valid,
  input logic          piece_ready,
  input logic          piece_dir,
  input logic [CW-1:0] piece_sx,
  input logic [CW-1:0] piece_sy,
  input logic [CW-1:0] piece_w,
  input logic [CW-1:0] piece_h,
  input logic [OW-1:0] piece_lin_off,
  input logic [CW-1:0] piece_utx,
  input logic [CW-1:0] piece_uty
);
  localparam int SW = 4 * UTW;
  localparam int SH = 4 * UTH;

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    piece_valid && !piece_ready |=> piece_valid && $stable(piece_sx) && $stable(piece_sy)
      && $stable(piece_w) && $stable(piece_h) && $stable(piece_lin_off)
      && $stable(piece_utx) && $stable(piece_uty) && $stable(piece_dir));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !piece_valid);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    align_err |-> !done && !piece_valid && !busy);

  p_piece_fits_r3: assert property (@(posedge clk) disable iff (rst)
    piece_valid |-> (piece_w != '0) && (piece_h != '0)
      && (32'(piece_sx) + 32'(piece_w) <= SW) && (32'(piece_sy) + 32'(piece_h) <= SH));

  p_utile_grid_r4: assert property (@(posedge clk) disable iff (rst)
    piece_valid |-> (piece_utx[1:0] == 2'b00) && (piece_uty[1:0] == 2'b00));
endmodule

bind region_walk_seq region_walk_seq_chk #(.UTW(UTW), .UTH(UTH), .CW(CW), .OW(OW)) i_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .align_err(align_err),
  .piece_valid(piece_valid), .piece_ready(piece_ready), .piece_dir(piece_dir),
  .piece_sx(piece_sx), .piece_sy(piece_sy), .piece_w(piece_w), .piece_h(piece_h),
  .piece_lin_off(piece_lin_off), .piece_utx(piece_utx), .piece_uty(piece_uty)
);

// File: tb/test_region_walk_seq.sv
module test_region_walk_seq;
  localparam int UTW = 8, UTH = 2, BPP = 4, CW = 12, OW = 24;
  localparam int SW = 4 * UTW, SH = 4 * UTH;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, dir = 1'b0, piece_ready = 1'b0;
  logic [CW-1:0] reg_x = '0, reg_y = '0, reg_w = '0, reg_h = '0;
  logic [OW-1:0] lin_stride = '0;
  logic busy, done, align_err, piece_valid, piece_dir;
  logic [CW-1:0] piece_sx, piece_sy, piece_w, piece_h, piece_utx, piece_uty;
  logic [OW-1:0] piece_lin_off;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  region_walk_seq #(.UTW(UTW), .UTH(UTH), .BPP(BPP), .CW(CW), .OW(OW)) i_region_walk_seq (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .reg_x(reg_x), .reg_y(reg_y),
    .reg_w(reg_w), .reg_h(reg_h), .lin_stride(lin_stride), .busy(busy), .done(done),
    .align_err(align_err), .piece_valid(piece_valid), .piece_ready(piece_ready),
    .piece_dir(piece_dir), .piece_sx(piece_sx), .piece_sy(piece_sy), .piece_w(piece_w),
    .piece_h(piece_h), .piece_lin_off(piece_lin_off), .piece_utx(piece_utx),
    .piece_uty(piece_uty)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(input int x, input int y, input int w, input int h,
                      input int stride, input bit d);
    @(negedge clk);
    reg_x = CW'(x); reg_y = CW'(y); reg_w = CW'(w); reg_h = CW'(h);
    lin_stride = OW'(stride); dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dir = ~d;
  endtask

  task automatic piece_fields(input int sx, input int sy, input int pw, input int ph,
                              input int lin, input int ux, input int uy, input bit d);
    chk("R2 valid", piece_valid, 1);
    chk("R3 sx", piece_sx, sx);
    chk("R3 sy", piece_sy, sy);
    chk("R3 w", piece_w, pw);
    chk("R3 h", piece_h, ph);
    chk("R5 lin_off", piece_lin_off, lin);
    chk("R4 utx", piece_utx, ux);
    chk("R4 uty", piece_uty, uy);
    chk("R10 dir", piece_dir, d);
  endtask

  task automatic walk(input int x, input int y, input int w, input int h,
                      input int stride, input bit d, input bit stall);
    int base = 0;
    int ey = y;
    int k = 0;
    kick(x, y, w, h, stride, d);
    chk("R9 no err", align_err, 0);
    while (ey < y + h) begin
      int sy = ey % SH;
      int ph = (y + h - ey < SH - sy) ? (y + h - ey) : (SH - sy);
      int ex = x;
      int coff = 0;
      while (ex < x + w) begin
        int sx = ex % SW;
        int pw = (x + w - ex < SW - sx) ? (x + w - ex) : (SW - sx);
        int ux = (ex / UTW) & ~3;
        int uy = (ey / UTH) & ~3;
        piece_fields(sx, sy, pw, ph, base + coff, ux, uy, d);
        chk("R7 no early done", done, 0);
        if (stall && k[0]) begin
          piece_ready = 1'b0;
          @(negedge clk);
          chk("R6 held valid", piece_valid, 1);
          piece_fields(sx, sy, pw, ph, base + coff, ux, uy, d);
        end
        piece_ready = 1'b1;
        @(negedge clk);
        piece_ready = 1'b0;
        coff += pw * BPP;
        ex = ex + pw;
        k++;
      end
      base += stride * ph;
      ey = ey + ph;
    end
    chk("R7 done", done, 1);
    chk("R7 busy low", busy, 0);
    chk("R2 no extra piece", piece_valid, 0);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 align_err", align_err, 0);
    chk("R1 valid", piece_valid, 0);

    // R8: empty regions finish at once
    for (int i = 0; i < 3; i++) begin
      kick(8 * i, 2 * i, (i == 1) ? 16 : 0, (i == 2) ? 4 : 0, 128, 1'b1);
      chk("R8 done", done, 1);
      chk("R8 no piece", piece_valid, 0);
      chk("R8 busy", busy, 0);
      @(negedge clk);
      chk("R8 done pulse", done, 0);
    end

    // R9: misaligned requests rejected
    for (int i = 0; i < 4; i++) begin
      kick((i == 0) ? 3 : 8, (i == 1) ? 1 : 2, (i == 2) ? 12 : 16, (i == 3) ? 3 : 4, 128, 1'b0);
      chk("R9 err", align_err, 1);
      chk("R9 no piece", piece_valid, 0);
      chk("R9 no done", done, 0);
      chk("R9 busy", busy, 0);
      @(negedge clk);
      chk("R9 err pulse", align_err, 0);
      chk("R9 still no piece", piece_valid, 0);
      chk("R9 still no done", done, 0);
    end

    // R2 R3 R4 R5 R6 R10: sweep of origins and extents
    for (int xi = 0; xi < 8; xi++)
      for (int yi = 0; yi < 8; yi++)
        for (int wi = 0; wi < 4; wi++)
          for (int hi = 0; hi < 4; hi++) begin
            int ws[4] = '{8, 24, 40, 72};
            int hs[4] = '{2, 6, 10, 18};
            walk(8 * xi, 2 * yi, ws[wi], hs[hi], 256 + 64 * (xi % 3),
                 bit'((xi + yi) & 1), bit'((wi + hi) & 1));
          end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule